// File: doc/BRIEF.md
# Indirect Register Command Bridge

This block gives a host access to the byte-wide internal registers of a two-wire serial bus controller through a single 64-bit command word. The host writes a word carrying a go flag, a read flag, a 4-bit opcode, a 3-bit sub-opcode and a data byte. The bridge holds the go flag high for a fixed number of cycles, then performs one access to the chosen internal register and clears the go flag. On a read, the register value is placed in the low byte of the word.

The internal register file is a small model. It holds a data byte, a control byte, a status byte, a clock-control byte and a clock half-period byte, and it accepts a controller reset command. The host polls bit 63 of the word to learn when the access is done. The serial bus engine itself is not part of this block.

Top module: `sbc_cmd_bridge`

## Requirements
- R1: After reset, `host_rdata` reads all zeros, so the go flag (bit 63) is low.
- R2: A write with bit 63 set, accepted while idle, shows bit 63 high for exactly HOLD cycles (default 4). After that, bit 63 reads 0.
- R3: A host write while bit 63 is high is ignored. The access in flight completes with its original word.
- R4: A host write with bit 63 clear is ignored. The word is unchanged and no access starts.
- R5: The field layout is as follows. Bits 60:57 are the opcode and bit 56 is the read flag. Bits 34:32 are the sub-opcode and bits 7:0 are the data. On completion, every bit other than bit 63 keeps its written value, except that a read replaces bits 7:0 with the register value. Opcode 6 with sub-opcode 1 selects the data register.
- R6: Opcode 6 with sub-opcode 2 selects the control register, which can be both written and read.
- R7: Opcode 4 selects the clock half-period register, which can be both written and read. Its reset value is 0x18.
- R8: Opcode 6 with sub-opcode 3 selects the status register when read. When written, it selects the clock-control register, and the status register does not change.
- R9: A control write with bit 5 set loads the status register with 0x08. A write with opcode 6 and sub-opcode 7 resets the controller: status becomes 0xF8 and control becomes 0x00, while the data register keeps its value.
- R10: Any other opcode or sub-opcode completes normally but changes no register, and a read of it returns 0x00. This includes a read with sub-opcode 7.
- R11: After reset, the data register reads 0x00, control reads 0x00 and status reads 0xF8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host write strobe for the command word |
| host_wdata | input | 64 | Command word written by the host |
| host_rdata | output | 64 | Current command word (go flag and read result) |

## Verification
The bench goes after three kinds of error. The first is the go-flag window. A bridge that miscounts HOLD shows the wrong number of busy samples, and one that accepts writes while busy finishes with the second word's data in the register. The second is the shared sub-opcode 3. A design that routes writes to status would break the idle value read back afterwards. The third is the reset command and unknown codes. A design that decodes them loosely either clears the data register or returns stale bytes instead of 0x00.

// File: rtl/sbc_bridge_pkg.sv
package sbc_bridge_pkg;
  typedef enum logic [2:0] {
    TGT_NONE, TGT_DATA, TGT_CTL, TGT_CLKCTL, TGT_STATUS, TGT_HALFPER, TGT_RESET
  } tgt_e;

  localparam int          GO_BIT        = 63;
  localparam int          RD_BIT        = 56;
  localparam int          OP_LSB        = 57;
  localparam int          SUB_LSB       = 32;
  localparam logic [3:0]  OP_HALFPER    = 4'd4;
  localparam logic [3:0]  OP_EXTENDED   = 4'd6;
  localparam logic [2:0]  SUB_DATA      = 3'd1;
  localparam logic [2:0]  SUB_CTL       = 3'd2;
  localparam logic [2:0]  SUB_CLK_STAT  = 3'd3;
  localparam logic [2:0]  SUB_RESET     = 3'd7;
  localparam logic [7:0]  STATUS_IDLE   = 8'hF8;
  localparam logic [7:0]  STATUS_STARTD = 8'h08;
  localparam logic [7:0]  HALFPER_INIT  = 8'h18;
  localparam int          CTL_START_POS = 5;
endpackage

// File: rtl/sbc_cmd_decode.sv
module sbc_cmd_decode
  import sbc_bridge_pkg::*;
(
  input  logic [3:0] op,
  input  logic [2:0] sub,
  input  logic       rd,
  output tgt_e       tgt
);
  always_comb begin
    tgt = TGT_NONE;
    if (op == OP_HALFPER) begin
      tgt = TGT_HALFPER;
    end else if (op == OP_EXTENDED) begin
      case (sub)
        SUB_DATA:     tgt = TGT_DATA;
        SUB_CTL:      tgt = TGT_CTL;
        SUB_CLK_STAT: tgt = rd ? TGT_STATUS : TGT_CLKCTL;
        SUB_RESET:    tgt = rd ? TGT_NONE : TGT_RESET;
        default:      tgt = TGT_NONE;
      endcase
    end
  end
endmodule

// File: rtl/sbc_reg_model.sv
module sbc_reg_model
  import sbc_bridge_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_en,
  input  tgt_e          tgt,
  input  logic          rd,
  input  logic [DW-1:0] wbyte,
  output logic [DW-1:0] rbyte
);
  logic [DW-1:0] data_q, ctl_q, stat_q, clk_q, hp_q;
  logic [DW-1:0] data_d, ctl_d, stat_d, clk_d, hp_d;
  logic          wr_en;

  assign wr_en = acc_en && !rd;

  always_comb begin
    data_d = data_q;
    ctl_d  = ctl_q;
    stat_d = stat_q;
    clk_d  = clk_q;
    hp_d   = hp_q;
    if (wr_en) begin
      case (tgt)
        TGT_DATA:    data_d = wbyte;
        TGT_CTL: begin
          ctl_d = wbyte;
          if (wbyte[CTL_START_POS]) stat_d = DW'(STATUS_STARTD);
        end
        TGT_CLKCTL:  clk_d = wbyte;
        TGT_HALFPER: hp_d = wbyte;
        TGT_RESET: begin
          ctl_d  = '0;
          stat_d = DW'(STATUS_IDLE);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      ctl_q  <= '0;
      stat_q <= DW'(STATUS_IDLE);
      clk_q  <= '0;
      hp_q   <= DW'(HALFPER_INIT);
    end else if (wr_en) begin
      data_q <= data_d;
      ctl_q  <= ctl_d;
      stat_q <= stat_d;
      clk_q  <= clk_d;
      hp_q   <= hp_d;
    end
  end

  always_comb begin
    case (tgt)
      TGT_DATA:    rbyte = data_q;
      TGT_CTL:     rbyte = ctl_q;
      TGT_STATUS:  rbyte = stat_q;
      TGT_HALFPER: rbyte = hp_q;
      default:     rbyte = '0;
    endcase
  end

  // R10: a cycle with no write to a known target leaves every register alone
  a_r10_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && tgt != TGT_NONE) |=> ($stable(data_q) && $stable(ctl_q) &&
      $stable(stat_q) && $stable(clk_q) && $stable(hp_q)));

  // R8: the clock-control write path never touches status
  a_r8_clkctl_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt == TGT_CLKCTL) |=> $stable(stat_q));

  // R9: a reset command leaves the status idle
  a_r9_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && tgt == TGT_RESET) |=> (stat_q == DW'(STATUS_IDLE) && ctl_q == '0));
endmodule

// File: rtl/sbc_cmd_bridge.sv
module sbc_cmd_bridge
  import sbc_bridge_pkg::*;
#(
  parameter int HOLD = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_wr,
  input  logic [63:0] host_wdata,
  output logic [63:0] host_rdata
);
  localparam int CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;

  logic [63:0]      cmd_q, cmd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy, accept, finish;
  tgt_e             tgt;
  logic [7:0]       rbyte;

  assign busy   = cmd_q[GO_BIT];
  assign accept = host_wr && host_wdata[GO_BIT] && !busy;
  assign finish = busy && (cnt_q == '0);

  sbc_cmd_decode u_decode (
    .op  (cmd_q[OP_LSB +: 4]),
    .sub (cmd_q[SUB_LSB +: 3]),
    .rd  (cmd_q[RD_BIT]),
    .tgt (tgt)
  );

  sbc_reg_model #(.DW(8)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .acc_en (finish),
    .tgt    (tgt),
    .rd     (cmd_q[RD_BIT]),
    .wbyte  (cmd_q[7:0]),
    .rbyte  (rbyte)
  );

  always_comb begin
    cmd_d = cmd_q;
    cnt_d = cnt_q;
    if (accept) begin
      cmd_d = host_wdata;
      cnt_d = CNT_W'(HOLD - 1);
    end else if (finish) begin
      cmd_d[GO_BIT] = 1'b0;
      if (cmd_q[RD_BIT]) cmd_d[7:0] = rbyte;
    end else if (busy) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= '0;
      cnt_q <= '0;
    end else if (accept || busy) begin
      cmd_q <= cmd_d;
      cnt_q <= cnt_d;
    end
  end

  assign host_rdata = cmd_q;

  // R3: while the hold window runs, the word is frozen whatever the host writes
  a_r3_busy_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt_q != '0) |=> (busy && $stable(cmd_q)));

  // R2: the go flag drops right after the final hold cycle
  a_r2_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !host_rdata[GO_BIT]);

  // R4: without a write that sets the go flag, an idle bridge stays idle
  a_r4_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(host_wr && host_wdata[GO_BIT])) |=> ($stable(host_rdata) && !busy));

  // R5: completion keeps the upper command fields as written
  a_r5_fields_kept: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (host_rdata[62:8] == $past(cmd_q[62:8])));
endmodule

// File: tb/sbc_cmd_bridge_bench.sv
`timescale 1ns/1ps
module sbc_cmd_bridge_bench;
  localparam int HOLD = 4;

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [63:0] host_wdata;
  logic [63:0] host_rdata;

  int       n_tests = 0;
  int       n_fail  = 0;
  int       run_len = 0;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;

  sbc_cmd_bridge #(.HOLD(HOLD)) u_sbc_cmd_bridge (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata)
  );

  function automatic logic [63:0] mk(input logic [3:0] op, input logic [2:0] sub,
                                     input logic rd, input logic [7:0] d);
    mk = {1'b1, 2'b00, op, rd, 21'd0, sub, 24'd0, d};
  endfunction

  function automatic logic [63:0] done_w(input logic [63:0] w, input logic [7:0] rb);
    done_w = w;
    done_w[63] = 1'b0;
    if (w[56]) done_w[7:0] = rb;
  endfunction

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: counts busy samples and scores each completion
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_rdata[63]) begin
        run_len++;
      end else if (run_len > 0) begin
        check64("R2 hold length", 64'(run_len), 64'(HOLD));
        if (sb_q.size() == 0) begin
          n_tests++;
          n_fail++;
          $display("FAIL R2: actual unexpected completion expected none");
        end else begin
          check64(sb_q[0].tag, host_rdata, sb_q[0].exp);
          void'(sb_q.pop_front());
        end
        run_len = 0;
      end
    end
  end

  task automatic issue(input string tag, input logic [63:0] w, input logic [7:0] rb,
                       input bit poke, input logic [63:0] pw);
    sb_item_t it;
    it.exp = done_w(w, rb);
    it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = w;
    @(negedge clk);
    if (poke) host_wdata = pw;
    else host_wr = 1'b0;
    @(negedge clk);
    host_wr = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] held;
    rst_n = 1'b0;
    host_wr = 1'b0;
    host_wdata = '0;
    repeat (3) @(negedge clk);
    check64("R1 reset word", host_rdata, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 / R7: reset values
    issue("R11 data reset",   mk(4'd6, 3'd1, 1'b1, 8'hC3), 8'h00, 1'b0, '0);
    issue("R11 ctl reset",    mk(4'd6, 3'd2, 1'b1, 8'h3C), 8'h00, 1'b0, '0);
    issue("R11 status reset", mk(4'd6, 3'd3, 1'b1, 8'h00), 8'hF8, 1'b0, '0);
    issue("R7 halfper reset", mk(4'd4, 3'd0, 1'b1, 8'h00), 8'h18, 1'b0, '0);
    // R5 data
    issue("R5 data write",    mk(4'd6, 3'd1, 1'b0, 8'h5A), 8'h00, 1'b0, '0);
    issue("R5 data read",     mk(4'd6, 3'd1, 1'b1, 8'hC3), 8'h5A, 1'b0, '0);
    // R6 control
    issue("R6 ctl write",     mk(4'd6, 3'd2, 1'b0, 8'h44), 8'h00, 1'b0, '0);
    issue("R6 ctl read",      mk(4'd6, 3'd2, 1'b1, 8'h00), 8'h44, 1'b0, '0);
    // R7 half period
    issue("R7 halfper write", mk(4'd4, 3'd0, 1'b0, 8'h9B), 8'h00, 1'b0, '0);
    issue("R7 halfper read",  mk(4'd4, 3'd0, 1'b1, 8'h00), 8'h9B, 1'b0, '0);
    // R8 clock control write leaves status
    issue("R8 clkctl write",  mk(4'd6, 3'd3, 1'b0, 8'h77), 8'h00, 1'b0, '0);
    issue("R8 status after",  mk(4'd6, 3'd3, 1'b1, 8'h00), 8'hF8, 1'b0, '0);
    // R9 start flag then controller reset
    issue("R9 ctl start",     mk(4'd6, 3'd2, 1'b0, 8'h60), 8'h00, 1'b0, '0);
    issue("R9 status start",  mk(4'd6, 3'd3, 1'b1, 8'h00), 8'h08, 1'b0, '0);
    issue("R9 reset cmd",     mk(4'd6, 3'd7, 1'b0, 8'h00), 8'h00, 1'b0, '0);
    issue("R9 status idle",   mk(4'd6, 3'd3, 1'b1, 8'h00), 8'hF8, 1'b0, '0);
    issue("R9 ctl cleared",   mk(4'd6, 3'd2, 1'b1, 8'h00), 8'h00, 1'b0, '0);
    issue("R9 data kept",     mk(4'd6, 3'd1, 1'b1, 8'h00), 8'h5A, 1'b0, '0);
    // R10 unknown codes
    issue("R10 bad op write", mk(4'd2, 3'd1, 1'b0, 8'h11), 8'h00, 1'b0, '0);
    issue("R10 bad sub write", mk(4'd6, 3'd5, 1'b0, 8'h12), 8'h00, 1'b0, '0);
    issue("R10 data intact",  mk(4'd6, 3'd1, 1'b1, 8'h00), 8'h5A, 1'b0, '0);
    issue("R10 bad op read",  mk(4'd2, 3'd1, 1'b1, 8'hFF), 8'h00, 1'b0, '0);
    issue("R10 bad sub read", mk(4'd6, 3'd5, 1'b1, 8'hFF), 8'h00, 1'b0, '0);
    issue("R10 sub7 read",    mk(4'd6, 3'd7, 1'b1, 8'hFF), 8'h00, 1'b0, '0);
    // R3 write while busy is ignored
    issue("R3 busy poke",     mk(4'd6, 3'd1, 1'b0, 8'h21), 8'h00, 1'b1,
          mk(4'd6, 3'd1, 1'b0, 8'hEE));
    issue("R3 data after poke", mk(4'd6, 3'd1, 1'b1, 8'h00), 8'h21, 1'b0, '0);

    // R4 write without go flag is ignored
    held = host_rdata;
    @(negedge clk);
    host_wr = 1'b1;
    host_wdata = {1'b0, 2'b00, 4'd6, 1'b0, 21'd0, 3'd1, 24'd0, 8'h99};
    @(negedge clk);
    host_wr = 1'b0;
    repeat (HOLD + 2) @(negedge clk);
    check64("R4 word unchanged", host_rdata, held);
    issue("R4 data unchanged", mk(4'd6, 3'd1, 1'b1, 8'h00), 8'h21, 1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule